// File: doc/BRIEF.md
# Bidirectional DShot Transmit-and-Capture Engine

This block sends one inverted DShot frame on up to eight motor lines at once and then listens for the telemetry replies on the same lines. Each channel gets a 16-bit frame, sent most significant bit first. In every bit cell the line is pulled low, then carries the inverted data bit, then returns high. The line rests high. After the last cell the engine keeps driving the lines high for a fixed turnaround time. It then releases them to their external pull-ups, so a motor controller that does not answer reads as a steady high.

Once the lines are released, the engine takes a snapshot of all the lines every six ticks and stores it into a 256-entry sample buffer, one bit per channel in each entry. Six ticks against a 32-tick reply bit gives a little over five samples per reply bit. When the buffer is full, capture stops and a done flag rises. Software or a downstream decoder then reads the samples through a synchronous read port. Any entry not written since the last start reads as all ones, which means "no reply". A programmable divider sets how many clocks make one tick, and so sets the line rate. Decoding the reply is left to the reader.

Top module: `dshot_bidir_engine`

## Requirements
- R1: After reset, pin_oe is 0, pin_out is all ones, done is 0, and every buffer entry reads as all ones.
- R2: A start pulse seen while idle drives every line as an output at high level for exactly one tick, beginning the cycle after the start edge.
- R3: Then 16 bit cells follow, 40 ticks each. Bit 15 goes first. Channel n sends frames[16n+15:16n]. The line is 0 for ticks 0-12 of a cell, the inverse of the data bit for ticks 13-26, and 1 for ticks 27-39.
- R4: After the last cell, the lines stay driven high for 64 ticks. Then pin_oe drops to 0.
- R5: After release, pin_in is resynchronized through two flops and stored every 6 ticks. The first store comes 6 ticks after the release. Sample k goes to buffer address k, and pin n goes to bit n.
- R6: A start makes every buffer entry read as all ones until it is rewritten. rd_data shows the entry at rd_addr one clock after the address is applied.
- R7: done rises when the 256th sample is stored, 2241 ticks after the start edge. It falls only when a new start is accepted.
- R8: One tick lasts rate_div+1 clocks. The divider restarts on an accepted start, so all timing scales exactly with rate_div+1.
- R9: start is ignored from acceptance until done. frames is captured at acceptance, and later changes to it have no effect on the frame being sent.
- R10: Once capture is complete, the lines stay released (pin_oe 0, pin_out all ones) until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transmit-and-capture cycle (honoured only when idle) |
| frames | input | 128 | Sixteen-bit frame per channel, channel n at bits 16n+15:16n |
| rate_div | input | 8 | Tick length minus one, in clocks |
| pin_in | input | 8 | Line levels seen at the pads |
| rd_addr | input | 8 | Sample buffer read address |
| pin_oe | output | 8 | Per-line output enable (1 = drive) |
| pin_out | output | 8 | Per-line driven level |
| rd_data | output | 8 | Sample read at the previous rd_addr |
| done | output | 1 | Capture finished, buffer complete |

## Verification
Every result is due at a fixed tick count after the clock edge that accepts start. Call that edge cycle zero and take rate_div at 0. The lead-in high is visible in cycle 0. Cell bits start in cycle 1. The turnaround hold covers cycles 641 to 704, and the release shows in cycle 705. Sample k is stored at edge 711+6k. done shows from cycle 2241. Each of these figures is multiplied by rate_div+1 when the divider is set higher. The driver computes the expected line and done state for every cycle from these figures and queues it. A monitor a quarter-period after each rising edge compares one queued entry per clock. A pin change placed exactly three edges before a chosen sample's edge tests the two-flop resynchronization boundary.

// File: rtl/dshot_bidir_pkg.sv
`timescale 1ns/1ps
package dshot_bidir_pkg;
    localparam int NCH      = 8;
    localparam int FBITS    = 16;
    localparam int T_LO     = 13;
    localparam int T_DAT    = 14;
    localparam int T_HI     = 13;
    localparam int GAP_T    = 64;
    localparam int SPACING  = 6;
    localparam int NSAMP    = 256;
    localparam int DIV_W    = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TX,
        ST_GAP,
        ST_RX
    } eng_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Level of one line at a given tick inside a bit cell (inverted signalling).
    function automatic logic cell_level(input int pos, input int lo, input int dat, input logic bitv);
        if (pos < lo)
            return 1'b0;
        else if (pos < lo + dat)
            return ~bitv;
        else
            return 1'b1;
    endfunction
endpackage

// File: rtl/dshot_tick_gen.sv
`timescale 1ns/1ps
module dshot_tick_gen #(
    parameter int DIV_W = dshot_bidir_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dshot_tx_shaper.sv
`timescale 1ns/1ps
module dshot_tx_shaper #(
    parameter int NCH   = dshot_bidir_pkg::NCH,
    parameter int FBITS = dshot_bidir_pkg::FBITS,
    parameter int T_LO  = dshot_bidir_pkg::T_LO,
    parameter int T_DAT = dshot_bidir_pkg::T_DAT,
    parameter int CW    = 6,
    localparam int BW   = $clog2(FBITS)
) (
    input  logic [NCH*FBITS-1:0] frame_q,
    input  logic [BW-1:0]        bit_idx,
    input  logic [CW-1:0]        pos,
    output logic [NCH-1:0]       lvl
);
    import dshot_bidir_pkg::*;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [FBITS-1:0] fr;
        assign fr = frame_q[ch*FBITS +: FBITS];
        always_comb begin
            lvl[ch] = cell_level(int'(pos), T_LO, T_DAT, fr[bit_idx]);
        end
    end
endmodule

// File: rtl/dshot_sample_buf.sv
`timescale 1ns/1ps
module dshot_sample_buf #(
    parameter int NCH   = dshot_bidir_pkg::NCH,
    parameter int NSAMP = dshot_bidir_pkg::NSAMP,
    localparam int AW   = $clog2(NSAMP)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  logic [NCH-1:0] pins,
    input  logic [AW-1:0]  raddr,
    output logic [NCH-1:0] rdata
);
    logic [NCH-1:0]   sync1, sync2;
    logic [NCH-1:0]   mem [NSAMP];
    logic [NSAMP-1:0] valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= '1;
            sync2 <= '1;
        end else begin
            sync1 <= pins;
            sync2 <= sync1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            valid <= '0;
        else if (we)
            valid[waddr] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= sync2;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '1;
        else
            rdata <= valid[raddr] ? mem[raddr] : '1;
    end

    // R6: two edges after a clear, nothing can have been rewritten yet
    assert_prefill_R6: assert property (@(posedge clk) disable iff (rst)
        $past(clear, 2) |-> (rdata == '1));
endmodule

// File: rtl/dshot_bidir_engine.sv
`timescale 1ns/1ps
module dshot_bidir_engine #(
    parameter int NCH     = dshot_bidir_pkg::NCH,
    parameter int FBITS   = dshot_bidir_pkg::FBITS,
    parameter int T_LO    = dshot_bidir_pkg::T_LO,
    parameter int T_DAT   = dshot_bidir_pkg::T_DAT,
    parameter int T_HI    = dshot_bidir_pkg::T_HI,
    parameter int GAP_T   = dshot_bidir_pkg::GAP_T,
    parameter int SPACING = dshot_bidir_pkg::SPACING,
    parameter int NSAMP   = dshot_bidir_pkg::NSAMP,
    parameter int DIV_W   = dshot_bidir_pkg::DIV_W,
    localparam int AW     = $clog2(NSAMP)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [NCH*FBITS-1:0] frames,
    input  logic [DIV_W-1:0]     rate_div,
    input  logic [NCH-1:0]       pin_in,
    input  logic [AW-1:0]        rd_addr,
    output logic [NCH-1:0]       pin_oe,
    output logic [NCH-1:0]       pin_out,
    output logic [NCH-1:0]       rd_data,
    output logic                 done
);
    import dshot_bidir_pkg::*;

    localparam int CELL    = T_LO + T_DAT + T_HI;
    localparam int CNT_MAX = max3(CELL, GAP_T, SPACING);
    localparam int CW      = $clog2(CNT_MAX);
    localparam int BW      = $clog2(FBITS);

    eng_state_e           state;
    logic [NCH*FBITS-1:0] frame_q;
    logic [BW-1:0]        bit_idx;
    logic [CW-1:0]        pos;
    logic [AW-1:0]        widx;
    logic                 tick;
    logic                 accept;
    logic                 wr_en;
    logic [NCH-1:0]       tx_lvl;

    assign accept = (state == ST_IDLE) && start;
    assign wr_en  = (state == ST_RX) && tick && (pos == CW'(SPACING-1));

    dshot_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .div     (rate_div),
        .tick    (tick)
    );

    dshot_tx_shaper #(
        .NCH(NCH), .FBITS(FBITS), .T_LO(T_LO), .T_DAT(T_DAT), .CW(CW)
    ) u_shaper (
        .frame_q (frame_q),
        .bit_idx (bit_idx),
        .pos     (pos),
        .lvl     (tx_lvl)
    );

    dshot_sample_buf #(.NCH(NCH), .NSAMP(NSAMP)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .we    (wr_en),
        .waddr (widx),
        .pins  (pin_in),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            frame_q <= '0;
            bit_idx <= '0;
            pos     <= '0;
            widx    <= '0;
            done    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state   <= ST_LEAD;
                    frame_q <= frames;
                    bit_idx <= BW'(FBITS-1);
                    pos     <= '0;
                    widx    <= '0;
                    done    <= 1'b0;
                end
                ST_LEAD: if (tick) begin
                    state <= ST_TX;
                    pos   <= '0;
                end
                ST_TX: if (tick) begin
                    if (pos == CW'(CELL-1)) begin
                        pos <= '0;
                        if (bit_idx == '0)
                            state <= ST_GAP;
                        else
                            bit_idx <= bit_idx - 1'b1;
                    end else begin
                        pos <= pos + 1'b1;
                    end
                end
                ST_GAP: if (tick) begin
                    if (pos == CW'(GAP_T-1)) begin
                        pos   <= '0;
                        state <= ST_RX;
                    end else begin
                        pos <= pos + 1'b1;
                    end
                end
                ST_RX: if (tick) begin
                    if (pos == CW'(SPACING-1)) begin
                        pos  <= '0;
                        widx <= widx + 1'b1;
                        if (widx == AW'(NSAMP-1)) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end
                    end else begin
                        pos <= pos + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        pin_oe  = '0;
        pin_out = '1;
        if (state == ST_LEAD || state == ST_TX || state == ST_GAP)
            pin_oe = '1;
        if (state == ST_TX)
            pin_out = tx_lvl;
    end

    // R10: a finished capture leaves every line released
    assert_done_released_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (pin_oe == '0));

    // R7: done only falls on an accepted start
    assert_done_fall_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(done) |-> $past(start));

    // R9: a start while transmitting does not disturb the sequence
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TX && start) |=> (state == ST_TX || state == ST_GAP));

    // R4: turnaround hold keeps the lines steady
    assert_gap_steady_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP && $past(state == ST_GAP)) |-> ($stable(pin_out) && $stable(pin_oe)));

    // R5: samples are stored only while the lines are released
    assert_store_released_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (pin_oe == '0));
endmodule

// File: tb/dshot_bidir_engine_bench.sv
`timescale 1ns/1ps
module dshot_bidir_engine_bench;
    localparam int TOTAL = 2241;  // ticks from start edge to done

    typedef struct packed {
        logic [7:0] oe;
        logic [7:0] out;
        logic       dn;
        logic [3:0] rq;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [127:0] frames = '0;
    logic [7:0]   rate_div = '0;
    logic [7:0]   pin_in = 8'hFF;
    logic [7:0]   rd_addr = '0;
    logic [7:0]   pin_oe, pin_out, rd_data;
    logic         done;

    int    checks = 0;
    int    errors = 0;
    item_t expq[$];

    always #2.5 clk = ~clk;

    dshot_bidir_engine u_dshot_bidir_engine (
        .clk(clk), .rst(rst), .start(start), .frames(frames), .rate_div(rate_div),
        .pin_in(pin_in), .rd_addr(rd_addr), .pin_oe(pin_oe), .pin_out(pin_out),
        .rd_data(rd_data), .done(done)
    );

    task automatic chk(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    // Expected line/done state for cycle j after the start edge (R2 R3 R4 R7 R8 R10)
    function automatic item_t exp_at(int j, int div, logic [127:0] fr);
        item_t it;
        int t;
        t = j / (div + 1);
        it.oe = 8'hFF; it.out = 8'hFF; it.dn = (t >= TOTAL);
        if (t == 0) it.rq = 4'd2;
        else if (t <= 640) begin
            int p, b;
            p = (t - 1) % 40;
            b = 15 - (t - 1) / 40;
            for (int ch = 0; ch < 8; ch++)
                it.out[ch] = (p < 13) ? 1'b0 : (p < 27) ? ~fr[ch*16 + b] : 1'b1;
            it.rq = 4'd3;
        end else if (t <= 704) it.rq = 4'd4;
        else begin
            it.oe = 8'h00;
            it.rq = (t >= TOTAL) ? 4'd7 : 4'd5;
        end
        return it;
    endfunction

    // Monitor: one queued item per clock, a quarter period after the edge
    always @(posedge clk) begin
        #1.25;
        if (expq.size() > 0) begin
            item_t e;
            e = expq.pop_front();
            chk(pin_oe == e.oe && pin_out == e.out && done == e.dn,
                $sformatf("R%0d", e.rq),
                {15'd0, done, pin_oe, pin_out}, {15'd0, e.dn, e.oe, e.out});
        end
    end

    // Driver: one full cycle. chg_at<0 means no pin change; stray start/frame change exercise R9.
    task automatic run_cycle(input logic [127:0] fr, input int div, input logic [7:0] pa,
                             input logic [7:0] pb, input int chg_at, input logic prefill_chk);
        int last;
        last = TOTAL * (div + 1);
        @(negedge clk);
        frames = fr; rate_div = 8'(div); pin_in = pa; start = 1'b1;
        for (int j = 0; j <= last; j++) expq.push_back(exp_at(j, div, fr));
        for (int j = 0; j <= last; j++) begin
            @(negedge clk);
            if (j == 0) start = 1'b0;
            if (j == 10) frames = ~fr;                 // R9: late frame change ignored
            if (j == 300) start = 1'b1;                // R9: stray start while sending
            if (j == 301) start = 1'b0;
            if (j == 1500) start = 1'b1;               // R9: stray start while capturing
            if (j == 1501) start = 1'b0;
            if (j == chg_at) pin_in = pb;
            if (prefill_chk && j == 2) rd_addr = 8'd0;
            if (prefill_chk && j == 3)
                chk(rd_data == 8'hFF, "R6 prefill", {24'd0, rd_data}, 32'hFF);
        end
        wait (expq.size() == 0);
    endtask

    task automatic readback(input logic [7:0] pa, input logic [7:0] pb, input int first_b);
        for (int k = 0; k <= 256; k++) begin
            @(negedge clk);
            if (k > 0) begin
                logic [7:0] e;
                e = (first_b >= 0 && k - 1 >= first_b) ? pb : pa;
                chk(rd_data == e, "R5 sample", {24'd0, rd_data}, {24'd0, e});
            end
            if (k < 256) rd_addr = 8'(k);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] fa, fb;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        rd_addr = 8'd7;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk(pin_oe == 8'h00, "R1 oe", {24'd0, pin_oe}, 32'h0);
        chk(pin_out == 8'hFF, "R1 out", {24'd0, pin_out}, 32'hFF);
        chk(done == 1'b0, "R1 done", {31'd0, done}, 32'h0);
        chk(rd_data == 8'hFF, "R1 buffer", {24'd0, rd_data}, 32'hFF);

        // Run A: tick per clock, constant reply pattern; channels 0 and 1 all-zero / all-one
        fa = '0;
        fa[31:16] = 16'hFFFF;
        for (int ch = 2; ch < 8; ch++) fa[ch*16 +: 16] = 16'hA5C3 ^ 16'(ch * 16'h1357);
        run_cycle(fa, 0, 8'h5A, 8'h5A, -1, 1'b0);
        readback(8'h5A, 8'h5A, -1);

        // R10: lines stay released while idle
        repeat (20) @(negedge clk);
        chk(pin_oe == 8'h00 && pin_out == 8'hFF, "R10 idle", {16'd0, pin_oe, pin_out}, 32'h00FF);
        chk(done == 1'b1, "R7 held", {31'd0, done}, 32'h1);

        // Run B: R8 slower tick, no reply (pull-ups), R6 prefill after previous data
        fb = '0;
        for (int ch = 0; ch < 8; ch++) fb[ch*16 +: 16] = 16'h8001 | 16'(ch << 5);
        run_cycle(fb, 1, 8'hFF, 8'hFF, -1, 1'b1);
        readback(8'hFF, 8'hFF, -1);

        // Run C: reply changes exactly three edges before sample 100 (R5 resync boundary)
        run_cycle(fa ^ fb, 0, 8'h3C, 8'hC3, 711 + 6*100 - 3, 1'b0);
        readback(8'h3C, 8'hC3, 100);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule